// File: doc/BRIEF.md
# Reset-Hold Duration Counter

This block measures how long an active-low system reset button has been held down. Firmware uses that length to tell a short press from a long one, and treats a long press as a request to restore factory settings. The button line is asynchronous to the block. It passes through a two-flop synchroniser. After that, a counter advances once per reference clock cycle, nominally 25 MHz or 40 ns per count, for as long as the line stays low.

The counter saturates at its all-ones value and does not wrap. It holds its value after the button is released, so software can read it at any later time. Only a software write clears it. A new press that comes before a clear adds to the held value. Software reads the count from a single 32-bit register. Writing that register with its top bit set returns the count to zero.

The counter width is a parameter. It defaults to 29 bits, which gives a span of about 21.4 seconds at 25 MHz.

Top module: `rst_hold_timer`

## Requirements
- R1: While the synchronised button line is low and the count is below its maximum, the count rises by exactly one on every clock edge.
- R2: The button line passes through two flops before it reaches the counter. If the line is low across exactly K rising edges, the count rises by exactly K, subject to R3. The first increment lands on the third edge after the line falls.
- R3: The count stops at 2^CNT_W-1, which is 2^29-1 by default. It never wraps to zero.
- R4: A register write with bit 31 equal to 1 sets the count to zero on that clock edge.
- R5: A register write with bit 31 equal to 0 has no effect on the count.
- R6: While the synchronised line is high, the count keeps its value.
- R7: A new low phase without a clear in between continues from the held count.
- R8: The read data carries the count in bits CNT_W-1:0 (28:0 by default). All higher bits, including bits 30:29 and bit 31, read as zero.
- R9: When a clear and an increment fall on the same edge, the count becomes zero.
- R10: After the block's own reset, the count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, nominally 25 MHz |
| por_n | input | 1 | Active-low reset of the block itself |
| btn_n | input | 1 | Asynchronous active-low reset button line being measured |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_data | input | 32 | Write data; bit 31 is the clear command |
| rd_data | output | 32 | Read data; the count is zero-extended to 32 bits |

## Verification
A software clear and a counting step can land on the same edge. The bench provokes this by holding the button low until the count is climbing, then issuing a clear write in the middle of the press. The read just after that edge must be exactly zero, because the lost increment must not appear. The read one cycle later must be one, because counting resumes from the cleared value.

// File: rtl/rst_hold_timer.sv
module rst_hold_timer #(
  parameter int CNT_W   = 29,
  parameter int CLR_BIT = 31
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        btn_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [1:0]       sync_q;
  logic [CNT_W-1:0] cnt_q;
  logic             held_low, clr, at_max;

  assign held_low = ~sync_q[1];
  assign clr      = wr_en & wr_data[CLR_BIT];
  assign at_max   = (cnt_q == CNT_MAX);

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], btn_n};

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)                  cnt_q <= '0;
    else if (clr)                cnt_q <= '0;
    else if (held_low && !at_max) cnt_q <= cnt_q + 1'b1;

  assign rd_data = {{(32-CNT_W){1'b0}}, cnt_q};

  assert_step_R1: assert property (@(posedge clk) disable iff (!por_n)
    (held_low && !at_max && !clr) |=> (cnt_q == $past(cnt_q) + 1'b1));
  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!por_n)
    (at_max && !clr) |=> at_max);
  assert_clear_R4_R9: assert property (@(posedge clk) disable iff (!por_n)
    clr |=> (cnt_q == '0));
  assert_hold_R6: assert property (@(posedge clk) disable iff (!por_n)
    (!held_low && !clr) |=> $stable(cnt_q));
  assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!por_n)
    rd_data[31:CNT_W] == '0);
endmodule

// File: tb/rst_hold_timer_test.sv
module rst_hold_timer_test;
  localparam int W   = 5;
  localparam int MAX = (1 << W) - 1;

  logic        clk = 0, por_n = 0, btn_n = 1, wr_en = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  rst_hold_timer #(.CNT_W(W)) uut (.*);

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write(input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0; wr_data = '0;
  endtask

  task automatic press(input int k);
    @(negedge clk); btn_n = 0;
    repeat (k) @(negedge clk);
    btn_n = 1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset value", rd_data, 0);
    por_n = 1;
    repeat (2) @(negedge clk);
    check("R10 after release", rd_data, 0);

    // R1 R2 R3 R6: sweep of press lengths across saturation
    for (int k = 0; k <= MAX + 8; k++) begin
      write(32'h8000_0000);
      check("R4 clear", rd_data, 0);
      press(k);
      check("R2/R1/R3 press length", rd_data, (k > MAX) ? MAX : k);
      repeat (5) @(negedge clk);
      check("R6 held after release", rd_data, (k > MAX) ? MAX : k);
    end

    // R8: upper bits zero when saturated
    check("R8 upper bits", {rd_data[31:W], {W{1'b0}}}, 0);

    // R5: write without clear bit
    write(32'h8000_0000);
    press(7);
    write(32'h7FFF_FFFF);
    check("R5 no-clear write", rd_data, 7);

    // R7: accumulate across presses
    press(6);
    check("R7 accumulate", rd_data, 13);
    press(30);
    check("R7/R3 accumulate to max", rd_data, MAX);

    // R9: clear while counting
    write(32'h8000_0000);
    @(negedge clk); btn_n = 0;
    repeat (6) @(negedge clk);
    check("R1 mid-press", rd_data, 4);
    wr_en = 1; wr_data = 32'h8000_0000;
    @(negedge clk); wr_en = 0; wr_data = '0;
    check("R9 clear beats increment", rd_data, 0);
    @(negedge clk);
    check("R9 resume after clear", rd_data, 1);
    btn_n = 1;
    repeat (4) @(negedge clk);
    check("R6 hold after clear-press", rd_data, 3);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule